// File: doc/BRIEF.md
# Selectable Polynomial Noise Generator

This block turns the toggle strobes of a bank of frequency dividers into per-channel audio levels. Four free-running shift-register noise sources (4, 5, 9 and 17 stages) advance on every master clock. Each channel has a control byte. A 3-bit shape code in that byte chooses how a divider strobe affects the channel's one-bit output. The strobe can flip the bit, or it can copy a noise bit into it. It can also be allowed through only when the 5-stage source currently outputs a one.

The channel bit then gates a 4-bit volume onto the channel's level output. A hold flag in the control byte bypasses the bit and presents the volume directly, so the level can act as a static D/A value. A configuration input swaps the 17-stage source for the 9-stage one wherever the long source is used. The top 8 bits of the selected long source are exposed as a random-number read port. Mixing of the channel levels happens elsewhere.

Top module: `noise_shaper`

## Requirements
- R1: After reset, every noise register holds all ones and every channel bit is 0. The random port therefore reads 0xFF, and each level reads 0 unless its hold flag is set.
- R2: Every noise register shifts one place toward bit 0 on each clock, and its bit 0 is its output. The new top bit is the XOR of bit 0 and a tap bit: bit 1 for the 4-stage source, bit 2 for the 5-stage source, and bit 5 for both the 9-stage and 17-stage sources.
- R3: While `short_long` is 0, the long source is the 17-stage register and `rnd` shows its bits 16..9. While `short_long` is 1, the long source is the 9-stage register and `rnd` shows its bits 8..1.
- R4: The control byte for channel c occupies `ctrl[8c+7:8c]`. Shape codes sit in bits 7..5 of that byte. Shape 101 or 111: every strobe inverts the channel bit on the next clock.
- R5: Shape 001 or 011: a strobe inverts the channel bit only when the 5-stage output is 1. Otherwise the bit is unchanged.
- R6: Shape 000 or 010: when a strobe arrives and the 5-stage output is 1, the channel bit takes the long-source output (000) or the 4-stage output (010). Otherwise the bit is unchanged.
- R7: Shape 100 or 110: every strobe loads the channel bit with the long-source output (100) or the 4-stage output (110).
- R8: Without a strobe on its `tick` bit, a channel's bit keeps its value.
- R9: When bit 4 of a control byte (the hold flag) is 1, the channel level equals that byte's bits 3..0, whatever the channel bit or strobes.
- R10: When the hold flag is 0, the channel level equals the volume in bits 3..0 while the channel bit is 1. It is 0 while the channel bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all noise registers step on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| short_long | input | 1 | 1 selects the 9-stage long source, 0 the 17-stage one |
| ctrl | input | 32 | Four control bytes: shape, hold flag, volume |
| tick | input | 4 | Per-channel divider toggle strobe, one clock wide |
| rnd | output | 8 | Top 8 bits of the selected long source |
| level | output | 16 | Four 4-bit channel levels, channel c at bits 4c+3..4c |

## Verification
The hardest condition to reach is a strobe that arrives while the 5-stage output is 0 in a gated shape. The bit must then hold. This condition is only visible because a later strobe behaves differently. The bench drives strobes at a random third of cycles across all eight shape codes in both long-source modes. The four channels use rotated shapes, so gated and ungated channels run side by side against the same noise values. A behavioural model predicts every channel bit and the random port on each cycle.

// File: rtl/noise_shaper.sv
module noise_shaper #(
  parameter int NUM_CH = 4,
  parameter int VOL_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        short_long,
  input  logic [NUM_CH*(VOL_W+4)-1:0] ctrl,
  input  logic [NUM_CH-1:0]           tick,
  output logic [7:0]                  rnd,
  output logic [NUM_CH*VOL_W-1:0]     level
);
  localparam int CTRL_W = VOL_W + 4;

  logic [3:0]  p4;
  logic [4:0]  p5;
  logic [8:0]  p9;
  logic [16:0] p17;
  logic        long_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p4  <= '1;
      p5  <= '1;
      p9  <= '1;
      p17 <= '1;
    end else begin
      p4  <= {p4[0] ^ p4[1], p4[3:1]};
      p5  <= {p5[0] ^ p5[2], p5[4:1]};
      p9  <= {p9[0] ^ p9[5], p9[8:1]};
      p17 <= {p17[0] ^ p17[5], p17[16:1]};
    end
  end

  assign long_bit = short_long ? p9[0] : p17[0];
  assign rnd      = short_long ? p9[8:1] : p17[16:9];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [2:0]       shape;
    logic             hold;
    logic [VOL_W-1:0] vol;
    logic             bit_q;
    logic             gate;
    logic             nxt;

    assign shape = ctrl[c*CTRL_W+VOL_W+1 +: 3];
    assign hold  = ctrl[c*CTRL_W+VOL_W];
    assign vol   = ctrl[c*CTRL_W +: VOL_W];
    assign gate  = shape[2] | p5[0];
    assign nxt   = shape[0] ? ~bit_q : (shape[1] ? p4[0] : long_bit);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                bit_q <= 1'b0;
      else if (tick[c] && gate)  bit_q <= nxt;
    end

    assign level[c*VOL_W +: VOL_W] = (hold | bit_q) ? vol : '0;
  end
endmodule

// File: rtl/noise_shaper_chk.sv
module noise_shaper_chk #(
  parameter int NUM_CH = 4,
  parameter int VOL_W  = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        short_long,
  input logic [NUM_CH*(VOL_W+4)-1:0] ctrl,
  input logic [NUM_CH-1:0]           tick,
  input logic [7:0]                  rnd,
  input logic [NUM_CH*VOL_W-1:0]     level
);
  localparam int CTRL_W = VOL_W + 4;

  AST_RND_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (short_long == $past(short_long)) |-> (rnd[6:0] == $past(rnd[7:1]))); // R2

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    wire [CTRL_W-1:0] cb  = ctrl[c*CTRL_W +: CTRL_W];
    wire [VOL_W-1:0]  lv  = level[c*VOL_W +: VOL_W];
    wire [VOL_W-1:0]  vol = cb[VOL_W-1:0];

    AST_HOLD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      cb[VOL_W] |-> (lv == vol)); // R9

    AST_LEVEL_CHOICE: assert property (@(posedge clk) disable iff (!rst_n)
      (lv == vol) || (lv == '0)); // R10

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick[c] |=> ((cb != $past(cb)) || (lv == $past(lv)))); // R8

    AST_PURE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[c] && cb[VOL_W+3] && cb[VOL_W+1] && !cb[VOL_W] && vol != '0)
      |=> ((cb != $past(cb)) || (lv != $past(lv)))); // R4
  end
endmodule

bind noise_shaper noise_shaper_chk #(.NUM_CH(NUM_CH), .VOL_W(VOL_W)) u_chk (.*);

// File: tb/noise_shaper_bench.sv
`timescale 1ns/1ps
module noise_shaper_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        short_long = 0;
  logic [31:0] ctrl = '0;
  logic [3:0]  tick = '0;
  logic [7:0]  rnd;
  logic [15:0] level;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  noise_shaper u_noise_shaper (
    .clk(clk), .rst_n(rst_n), .short_long(short_long),
    .ctrl(ctrl), .tick(tick), .rnd(rnd), .level(level));

  int m4 = 15, m5 = 31, m9 = 511, m17 = 131071;
  int mq[4] = '{0, 0, 0, 0};
  int mlt[4] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m4 = 15; m5 = 31; m9 = 511; m17 = 131071;
      for (int c = 0; c < 4; c++) begin mq[c] = 0; mlt[c] = 0; end
    end else begin
      int b4, b5, bl, sh, f;
      b4 = m4 % 2; b5 = m5 % 2;
      bl = short_long ? (m9 % 2) : (m17 % 2);
      for (int c = 0; c < 4; c++) begin
        sh = ctrl[c*8+5 +: 3];
        mlt[c] = tick[c];
        if (tick[c] && (sh >= 4 || b5 == 1)) begin
          if (sh % 2 == 1)      mq[c] = 1 - mq[c];
          else if (sh % 4 == 2) mq[c] = b4;
          else                  mq[c] = bl;
        end
      end
      f = (m4 ^ (m4 >> 1)) & 1;   m4  = (m4 >> 1)  | (f << 3);
      f = (m5 ^ (m5 >> 2)) & 1;   m5  = (m5 >> 1)  | (f << 4);
      f = (m9 ^ (m9 >> 5)) & 1;   m9  = (m9 >> 1)  | (f << 8);
      f = (m17 ^ (m17 >> 5)) & 1; m17 = (m17 >> 1) | (f << 16);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    int er, ev, sh;
    string tag;
    er = short_long ? ((m9 >> 1) & 255) : ((m17 >> 9) & 255);
    chk(rnd == er, short_long ? "R3 rnd" : "R2 rnd", rnd, er);
    for (int c = 0; c < 4; c++) begin
      sh = ctrl[c*8+5 +: 3];
      ev = (ctrl[c*8+4] || mq[c] == 1) ? int'(ctrl[c*8 +: 4]) : 0;
      if (ctrl[c*8+4])        tag = "R9 level";
      else if (!mlt[c])       tag = "R8 level";
      else if (sh % 2 == 1)   tag = (sh >= 4) ? "R4 level" : "R5 level";
      else                    tag = (sh >= 4) ? "R7 level" : "R6 level";
      chk(level[c*4 +: 4] == ev, tag, level[c*4 +: 4], ev);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(rnd == 8'hFF, "R1 rnd", rnd, 255);
    chk(level == 16'h0, "R1 level", level, 0);
    ctrl[7:0] = {3'b101, 1'b0, 4'd9};
    @(negedge clk);
    chk(level[3:0] == 0, "R10 bit0", level[3:0], 0);
    tick[0] = 1;
    @(negedge clk);
    tick[0] = 0;
    chk(level[3:0] == 9, "R10 bit1", level[3:0], 9);
    tick[0] = 1;
    @(negedge clk);
    tick[0] = 0;
    chk(level[3:0] == 0, "R10 bit0 again", level[3:0], 0);
    compare_all();
    for (int mode = 0; mode < 2; mode++) begin
      short_long = mode[0];
      for (int code = 0; code < 8; code++) begin
        for (int c = 0; c < 4; c++) begin
          ctrl[c*8+5 +: 3] = 3'((code + c) % 8);
          ctrl[c*8+4]      = (code == 6 && c == 2);
          ctrl[c*8 +: 4]   = 4'($urandom_range(0, 15));
        end
        for (int k = 0; k < 200; k++) begin
          for (int c = 0; c < 4; c++) tick[c] = ($urandom_range(0, 2) == 0);
          @(negedge clk);
          compare_all();
        end
      end
    end
    tick = '0;
    repeat (3) begin @(negedge clk); compare_all(); end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule